// File: doc/BRIEF.md
# SCL Bit Rate Generator

This block times the SCL clock of an I2C master. A selectable power-of-two prescaler divides the reference clock. Two 5-bit period fields set the length of the SCL low phase and of the SCL high phase. Each phase also gets a fixed number of extra prescaled cycles, which stand for the internal synchroniser and noise filter. The block drives SCL low for the low phase and then releases it. It counts the high phase only after the synchronised SCL line has actually gone high, so a target that stretches the clock lengthens the high phase.

The transfer engine holds `run_i` high while it wants clock pulses. Each pulse gives it two strobes. The first comes in the middle of the low phase, when it may change SDA. The second comes on the last cycle of the high phase, when it should sample SDA. A small register port holds the prescaler select, which has a same-write protect bit, the two period fields and a fast-mode-plus enable. While the controller is disabled or held in internal reset, SCL stays released and all counters stay cleared. The registers keep their values during that time, so they can be programmed then.

Top module: `scl_rate_gen`

## Requirements
- R1: The prescaler select sits in bits 6:4 of address 0 and divides the reference clock by 2^select. A write to address 0 changes the select only when bit 3 of the same write data is 1. Address 0 reads back the select in bits 6:4 and zeros elsewhere. The select resets to 0.
- R2: The high period field sits at address 1 and the low period field at address 2, each in bits 4:0. Bits 7:5 of both read as 1. Both fields reset to 0x1F.
- R3: Bit 7 of address 3 is the fast-mode-plus enable. It drives `fmp_en_o` and reads back in bit 7, with zeros elsewhere. It resets to 0.
- R4: The low phase (`scl_drive_low_o` = 1) lasts (low field + K) × 2^select reference cycles. K is 4 when the select is 0 and 3 otherwise.
- R5: After SCL is released, the high count starts only once the SCL input, passed through a two-flop synchroniser, reads 1. The released time is therefore 3 cycles plus any stretch, plus (high field + K) × 2^select.
- R6: A period field of 0 acts as 1.
- R7: While `enable_i` is 0 or `soft_rst_i` is 1, SCL is released and both strobes are 0 from the next cycle on. Counting restarts with a fresh low phase afterwards.
- R8: `sda_upd_o` pulses once per low phase. The pulse lands on the last reference cycle of prescaled cycle index floor((low field + K − 1)/2), counted from 0.
- R9: `sample_o` pulses on the last cycle of the high phase. A new low phase then starts if `run_i` is 1; otherwise the block goes idle with SCL released.
- R10: After reset SCL is released, both strobes are 0 and `fmp_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Controller enable |
| soft_rst_i | input | 1 | Controller internal reset; clears counters, keeps registers |
| run_i | input | 1 | Transfer engine requests SCL pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| scl_i | input | 1 | SCL line level |
| scl_drive_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_upd_o | output | 1 | Strobe in the middle of the low phase |
| sample_o | output | 1 | Strobe on the last cycle of the high phase |
| fmp_en_o | output | 1 | Fast-mode-plus enable |

## Verification
The assertions run on every cycle. They check that the protect bit guards the select, that the high phase is entered only from a synchronised high level, that the block drops to released and silent after a disable or internal reset, that the SDA-update strobe only fires while SCL is held low, and that the state after a sample strobe follows `run_i`. The exact phase lengths for each select value appear only in the bench's scenarios. The same holds for the ×4 overhead at select 0 against ×3 elsewhere, the zero-period clamp, the placement of the mid-low strobe, and the lengthening of the high phase by a stretching target. The bench compares all of these cycle by cycle against its own timing model.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_WAIT, PH_HIGH} phase_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_HIGH = 2'd1;
  localparam logic [1:0] ADDR_LOW  = 2'd2;
  localparam logic [1:0] ADDR_FUNC = 2'd3;

  localparam int SEL_LSB  = 4;
  localparam int PROT_BIT = 3;
  localparam int FMP_BIT  = 7;
endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
  import scl_gen_pkg::*;
#(
  parameter int PS_W   = 3,
  parameter int PER_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PS_W-1:0]   sel_o,
  output logic [PER_W-1:0]  hi_per_o,
  output logic [PER_W-1:0]  lo_per_o,
  output logic              fmp_o
);
  logic [PS_W-1:0]  sel_q;
  logic [PER_W-1:0] hi_q, lo_q;
  logic             fmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      hi_q  <= '1;
      lo_q  <= '1;
      fmp_q <= 1'b0;
    end else if (wr_i) begin
      unique case (addr_i)
        ADDR_MODE: if (wdata_i[PROT_BIT]) sel_q <= wdata_i[SEL_LSB +: PS_W];
        ADDR_HIGH: hi_q  <= wdata_i[PER_W-1:0];
        ADDR_LOW:  lo_q  <= wdata_i[PER_W-1:0];
        ADDR_FUNC: fmp_q <= wdata_i[FMP_BIT];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_MODE: rdata_o[SEL_LSB +: PS_W] = sel_q;
      ADDR_HIGH: begin rdata_o = '1; rdata_o[PER_W-1:0] = hi_q; end
      ADDR_LOW:  begin rdata_o = '1; rdata_o[PER_W-1:0] = lo_q; end
      ADDR_FUNC: rdata_o[FMP_BIT] = fmp_q;
      default: ;
    endcase
  end

  assign sel_o    = sel_q;
  assign hi_per_o = hi_q;
  assign lo_per_o = lo_q;
  assign fmp_o    = fmp_q;

  // R1: select held unless the protect bit accompanies the write
  a_r1_sel_protect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_MODE && !wdata_i[PROT_BIT]) |=> $stable(sel_q));
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [PS_W-1:0] sel_i,
  output logic            tick_o
);
  localparam int CNT_W = (2 ** PS_W) - 1;

  logic [CNT_W-1:0] pre_q, lim;

  assign lim    = CNT_W'((64'd1 << sel_i) - 64'd1);
  assign tick_o = (pre_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (clr_i || tick_o)   pre_q <= '0;
    else                        pre_q <= pre_q + CNT_W'(1);
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int PS_W     = 3,
  parameter int PER_W    = 5,
  parameter int OVH_DIV1 = 4,
  parameter int OVH_DIVN = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             run_i,
  input  logic             scl_hi_i,
  input  logic             tick_i,
  input  logic [PS_W-1:0]  sel_i,
  input  logic [PER_W-1:0] hi_per_i,
  input  logic [PER_W-1:0] lo_per_i,
  output logic             clr_o,
  output logic             drive_low_o,
  output logic             sda_upd_o,
  output logic             sample_o
);
  localparam int LEN_W = PER_W + 2;

  phase_e           phase_q, phase_d;
  logic [LEN_W-1:0] ph_cnt_q, len, hi_eff, lo_eff, ovh;
  logic             last, ld;

  assign hi_eff = (hi_per_i == '0) ? LEN_W'(1) : LEN_W'(hi_per_i);
  assign lo_eff = (lo_per_i == '0) ? LEN_W'(1) : LEN_W'(lo_per_i);
  assign ovh    = (sel_i == '0) ? LEN_W'(OVH_DIV1) : LEN_W'(OVH_DIVN);
  assign len    = (phase_q == PH_HIGH) ? hi_eff + ovh : lo_eff + ovh;
  assign last   = (ph_cnt_q >= len - LEN_W'(1));

  always_comb begin
    phase_d = phase_q;
    ld      = 1'b0;
    if (!active_i) begin
      phase_d = PH_IDLE;
      ld      = 1'b1;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (run_i) begin phase_d = PH_LOW; ld = 1'b1; end
        PH_LOW:  if (tick_i && last) begin phase_d = PH_WAIT; ld = 1'b1; end
        PH_WAIT: if (scl_hi_i) begin phase_d = PH_HIGH; ld = 1'b1; end
        PH_HIGH: if (tick_i && last) begin
          phase_d = run_i ? PH_LOW : PH_IDLE;
          ld      = 1'b1;
        end
        default: begin phase_d = PH_IDLE; ld = 1'b1; end
      endcase
    end
  end

  assign clr_o = ld || phase_q == PH_IDLE || phase_q == PH_WAIT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      ph_cnt_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (clr_o)       ph_cnt_q <= '0;
      else if (tick_i) ph_cnt_q <= ph_cnt_q + LEN_W'(1);
    end
  end

  assign drive_low_o = (phase_q == PH_LOW);
  assign sda_upd_o   = (phase_q == PH_LOW) && tick_i &&
                       (ph_cnt_q == ((len - LEN_W'(1)) >> 1));
  assign sample_o    = (phase_q == PH_HIGH) && tick_i && last;

  // R5: high count only begins after the synchronised line read high
  a_r5_high_after_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HIGH && $past(phase_q) == PH_WAIT) |-> $past(scl_hi_i));
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_gen_pkg::*;
#(
  parameter int PS_W        = 3,
  parameter int PER_W       = 5,
  parameter int OVH_DIV1    = 4,
  parameter int OVH_DIVN    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       soft_rst_i,
  input  logic       run_i,
  input  logic       reg_wr_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       scl_i,
  output logic       scl_drive_low_o,
  output logic       sda_upd_o,
  output logic       sample_o,
  output logic       fmp_en_o
);
  logic [PS_W-1:0]        sel;
  logic [PER_W-1:0]       hi_per, lo_per;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   active, tick, clr;

  assign active = enable_i && !soft_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], scl_i};
  end

  scl_cfg_regs #(.PS_W(PS_W), .PER_W(PER_W), .DATA_W(8)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .sel_o    (sel),
    .hi_per_o (hi_per),
    .lo_per_o (lo_per),
    .fmp_o    (fmp_en_o)
  );

  scl_prescaler #(.PS_W(PS_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .sel_i  (sel),
    .tick_o (tick)
  );

  scl_phase_fsm #(
    .PS_W(PS_W), .PER_W(PER_W), .OVH_DIV1(OVH_DIV1), .OVH_DIVN(OVH_DIVN)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .run_i       (run_i),
    .scl_hi_i    (sync_q[SYNC_STAGES-1]),
    .tick_i      (tick),
    .sel_i       (sel),
    .hi_per_i    (hi_per),
    .lo_per_i    (lo_per),
    .clr_o       (clr),
    .drive_low_o (scl_drive_low_o),
    .sda_upd_o   (sda_upd_o),
    .sample_o    (sample_o)
  );

  // R7: disabled or in internal reset -> released and silent next cycle
  a_r7_off_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (!scl_drive_low_o && !sda_upd_o && !sample_o));
  // R8: the SDA update strobe only appears while SCL is pulled low
  a_r8_upd_in_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_upd_o |-> scl_drive_low_o);
  // R9: after a sample strobe the next phase follows run_i
  a_r9_sample_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && run_i && active) |=> scl_drive_low_o);
  a_r9_sample_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && !run_i) |=> !scl_drive_low_o);
endmodule

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       enable_i = 1'b0, soft_rst_i = 1'b0, run_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [7:0] reg_wdata_i = 8'd0;
  logic [7:0] reg_rdata_o;
  logic       scl_i = 1'b1;
  logic       scl_drive_low_o, sda_upd_o, sample_o, fmp_en_o;

  int errors = 0, checks = 0;
  bit done = 0;
  string tag = "R10";

  // bench shadow of the configuration
  int sh_sel = 0, sh_hi = 31, sh_lo = 31;
  // behavioural timing model
  int ms = 0, mt = 0, ms1 = 0, ms2 = 0;
  int stretch_len = 0, hold = 0;

  always #2 clk_i = ~clk_i;

  scl_rate_gen dut (.*);

  function automatic int ovh_f(); return (sh_sel == 0) ? 4 : 3; endfunction
  function automatic int eff_f(int v); return (v == 0) ? 1 : v; endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ms = 0; mt = 0; ms1 = 0; ms2 = 0;
    end else begin
      int p, lo_c, hi_c;
      p    = 1 << sh_sel;
      lo_c = (eff_f(sh_lo) + ovh_f()) * p;
      hi_c = (eff_f(sh_hi) + ovh_f()) * p;
      if (!enable_i || soft_rst_i) begin ms = 0; mt = 0; end
      else case (ms)
        0: if (run_i) begin ms = 1; mt = 0; end
        1: begin mt++; if (mt == lo_c) begin ms = 2; mt = 0; end end
        2: if (ms2 == 1) begin ms = 3; mt = 0; end
        default: begin mt++; if (mt == hi_c) begin ms = run_i ? 1 : 0; mt = 0; end end
      endcase
      ms2 = ms1; ms1 = int'(scl_i);
    end
  end

  // compare every cycle, then drive the SCL line model
  always @(negedge clk_i) begin
    int p, m;
    bit e_low, e_upd, e_smp;
    p = 1 << sh_sel;
    m = (eff_f(sh_lo) + ovh_f() - 1) >> 1;
    e_low = (ms == 1);
    e_upd = (ms == 1) && (mt == m * p + p - 1);
    e_smp = (ms == 3) && (mt == (eff_f(sh_hi) + ovh_f()) * p - 1);
    checks++;
    if (scl_drive_low_o !== e_low || sda_upd_o !== e_upd || sample_o !== e_smp) begin
      errors++;
      $display("FAIL %s t=%0t low/upd/smp act=%b%b%b exp=%b%b%b", tag, $time,
               scl_drive_low_o, sda_upd_o, sample_o, e_low, e_upd, e_smp);
    end
    if (scl_drive_low_o) begin scl_i = 1'b0; hold = stretch_len; end
    else if (hold > 0) begin hold--; scl_i = 1'b0; end
    else scl_i = 1'b1;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    #1;
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    #1;
    reg_wr_i = 1'b0;
    case (a)
      2'd0: if (d[3]) sh_sel = int'(d[6:4]);
      2'd1: sh_hi = int'(d[4:0]);
      2'd2: sh_lo = int'(d[4:0]);
      default: ;
    endcase
  endtask

  task automatic chk_rd(input logic [1:0] a, input logic [7:0] exp, input string t);
    @(negedge clk_i);
    #1;
    reg_addr_i = a;
    #1;
    checks++;
    if (reg_rdata_o !== exp) begin
      errors++;
      $display("FAIL %s read addr %0d act=%h exp=%h", t, a, reg_rdata_o, exp);
    end
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", t, act, exp);
    end
  endtask

  task automatic run_for(input int n, input int idle_n);
    @(negedge clk_i); #1; run_i = 1'b1;
    repeat (n) @(negedge clk_i);
    #1; run_i = 1'b0;
    repeat (idle_n) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1; rst_ni = 1'b1;
    // R10 reset state
    @(negedge clk_i); #1;
    chk_bit(scl_drive_low_o, 1'b0, "R10 scl released");
    chk_bit(sample_o | sda_upd_o, 1'b0, "R10 strobes quiet");
    chk_bit(fmp_en_o, 1'b0, "R10 fmp");
    chk_rd(2'd0, 8'h00, "R1 select reset");
    chk_rd(2'd1, 8'hFF, "R2 high reset");
    chk_rd(2'd2, 8'hFF, "R2 low reset");
    // R1 protect
    wr(2'd0, 8'h30);
    chk_rd(2'd0, 8'h00, "R1 unprotected write ignored");
    wr(2'd0, 8'h58);
    chk_rd(2'd0, 8'h50, "R1 protected write taken");
    // R2 field and fill bits
    wr(2'd1, 8'h05);
    chk_rd(2'd1, 8'hE5, "R2 high field");
    wr(2'd2, 8'h1A);
    chk_rd(2'd2, 8'hFA, "R2 low field");
    // R3
    wr(2'd3, 8'h80);
    chk_rd(2'd3, 8'h80, "R3 readback");
    chk_bit(fmp_en_o, 1'b1, "R3 fmp set");
    wr(2'd3, 8'h00);
    chk_bit(fmp_en_o, 1'b0, "R3 fmp clear");

    enable_i = 1'b1;
    tag = "R4 R8 R9 select0";
    wr(2'd0, 8'h08); wr(2'd2, 8'h05); wr(2'd1, 8'h03);
    run_for(200, 100);
    tag = "R4 R8 R9 select2";
    wr(2'd0, 8'h28); wr(2'd2, 8'h02); wr(2'd1, 8'h01);
    run_for(400, 200);
    tag = "R6 zero periods";
    wr(2'd0, 8'h18); wr(2'd2, 8'h00); wr(2'd1, 8'h00);
    run_for(150, 100);
    tag = "R5 stretch";
    wr(2'd0, 8'h08); wr(2'd2, 8'h03); wr(2'd1, 8'h02);
    stretch_len = 7;
    run_for(200, 100);
    stretch_len = 0;
    tag = "R7 disable";
    @(negedge clk_i); #1; run_i = 1'b1;
    repeat (57) @(negedge clk_i);
    #1; enable_i = 1'b0;
    repeat (5) @(negedge clk_i);
    #1; enable_i = 1'b1;
    repeat (43) @(negedge clk_i);
    #1; soft_rst_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk_bit(scl_drive_low_o, 1'b0, "R7 released in internal reset");
    #1; soft_rst_i = 1'b0;
    repeat (60) @(negedge clk_i);
    #1; run_i = 1'b0;
    repeat (80) @(negedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule